// File: doc/BRIEF.md
# Two-Level Multi-Owner Interrupt Aggregator

This block gathers single-cycle event pulses from DMA channels, audio interfaces and interface groups and turns them into one interrupt line per owner. There are seven event classes. Every event sets a sticky status bit for its class and resource. Map registers assign each DMA channel, each interface and each group to exactly one owner. Each owner therefore sees only the status bits of the resources it currently holds.

Software reads an owner's class summary first. It then reads the detailed status of a flagged class and clears the bits it has handled by writing ones to them. Per-owner class enables decide which classes may reach the summary and the interrupt line. Status still latches when a class is disabled.

Access goes through a plain register port. A write takes effect at the next clock edge. Read data is combinational from the address while `reg_valid` is high and `reg_write` is low.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset, all status bits, all map entries (owner 0) and all class enables are zero, and every `irq` bit is low.
- R2: An event pulse sets a sticky status bit for its class and resource, and the bit stays set until it is cleared. Class codes: 0 DMA period, 1 DMA underflow/overflow, 2 DMA error response, 3 interface underflow/overflow, 4 group done, 5 rate detector, 6 variable-frame-rate. Status register address is {2'b11, owner[2:0], class[2:0]}, and bit r is resource r.
- R3: A write to an owner's status register clears the status bits that have a one in the write data and belong to that owner. Zero bits have no effect, and bits owned by another owner are not affected.
- R4: If an event arrives in the same cycle as a write clearing the same bit, the bit stays set.
- R5: Summary bit c of an owner is high when class c is enabled for that owner and at least one of the owner's status bits in class c is set. The summary is read at {2'b10, 3'b000, owner[2:0]}.
- R6: `irq[o]` is the OR of owner o's summary bits.
- R7: Class enables are written at {2'b01, 3'b000, owner[2:0]}, with data bit c enabling class c. A disabled class still latches status but raises neither the summary bit nor the interrupt.
- R8: A map write at {2'b00, kind[1:0], index[3:0]} sets the owner in data[2:0]. Kind codes are 0 DMA, 1 interface, 2 group. The new mapping is visible from the next cycle, and any pending status of that resource then appears only under the new owner.
- R9: A map write whose data is not below the owner count is ignored, and the entry keeps its previous owner.
- R10: Classes 0 to 2 are owned through the DMA map by channel index. Classes 3, 5 and 6 are owned through the interface map by interface index. Class 4 is owned through the group map by group index.
- R11: Reads of an owner, class, kind or index beyond the configured counts return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_dma_period | input | N_DMA | DMA period events, one per channel |
| evt_dma_xrun | input | N_DMA | DMA underflow/overflow events |
| evt_dma_err | input | N_DMA | DMA error-response events |
| evt_if_xrun | input | N_INTF | Interface underflow/overflow events |
| evt_grp_done | input | N_GRP | Interface group done events |
| evt_rate | input | N_INTF | Rate detector events, per interface |
| evt_vfr | input | N_INTF | Variable-frame-rate events, per interface |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when no read is active |
| irq | output | N_OWN | One interrupt line per owner |

## Verification
The assertions assume that the event inputs, `reg_valid`, `reg_write`, `reg_addr` and `reg_wdata` are known values at every clock edge after reset. They also assume that an event is a level sampled at the edge, with no meaning between edges. The bench drives every input from the falling edge and never leaves one undriven. Its random phase draws map data that includes out-of-range owners, clear masks that cross ownership boundaries, and events that coincide with clears. All of these are legal stimulus, so the properties must hold under them.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt aggregator: event classes, resource
// kinds, register regions and small elaboration-time helpers.
package irq_agg_pkg;
    localparam int NCLS = 7;
    localparam int AW   = 8;
    localparam int DW   = 32;

    typedef enum logic [2:0] {
        CLS_DMA_PERIOD = 3'd0,
        CLS_DMA_XRUN   = 3'd1,
        CLS_DMA_ERR    = 3'd2,
        CLS_IF_XRUN    = 3'd3,
        CLS_GRP_DONE   = 3'd4,
        CLS_RATE       = 3'd5,
        CLS_VFR        = 3'd6
    } cls_e;

    typedef enum logic [1:0] {
        KIND_DMA  = 2'd0,
        KIND_INTF = 2'd1,
        KIND_GRP  = 2'd2
    } kind_e;

    localparam logic [1:0] RGN_MAP  = 2'd0;
    localparam logic [1:0] RGN_EN   = 2'd1;
    localparam logic [1:0] RGN_SUM  = 2'd2;
    localparam logic [1:0] RGN_STAT = 2'd3;

    // Which map decides ownership of a given class (R10)
    function automatic kind_e class_kind(input int c);
        if (c <= int'(CLS_DMA_ERR))       return KIND_DMA;
        else if (c == int'(CLS_GRP_DONE)) return KIND_GRP;
        else                              return KIND_INTF;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/irq_agg_cfg.sv
// Configuration registers: resource-to-owner maps and per-owner class
// enables. Assumes a write strobe that is already qualified by valid.
// Map writes with an owner value outside the owner count are dropped.
module irq_agg_cfg
    import irq_agg_pkg::*;
#(
    parameter int N_DMA  = 8,
    parameter int N_INTF = 4,
    parameter int N_GRP  = 2,
    parameter int N_OWN  = 5,
    parameter int OW     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wdata,
    output logic [N_DMA-1:0][OW-1:0]      dma_map,
    output logic [N_INTF-1:0][OW-1:0]     if_map,
    output logic [N_GRP-1:0][OW-1:0]      grp_map,
    output logic [N_OWN-1:0][NCLS-1:0]    cls_en
);
    logic map_ok, map_bad, en_wr;

    assign map_ok  = wr_en && (addr[7:6] == RGN_MAP) && (wdata <  DW'(N_OWN));
    assign map_bad = wr_en && (addr[7:6] == RGN_MAP) && (wdata >= DW'(N_OWN));
    assign en_wr   = wr_en && (addr[7:6] == RGN_EN);

    for (genvar i = 0; i < N_DMA; i++) begin : g_dma
        // DMA channel owner register
        always_ff @(posedge clk) begin
            if (!rst_n)
                dma_map[i] <= '0;
            else if (map_ok && addr[5:4] == KIND_DMA && int'(addr[3:0]) == i)
                dma_map[i] <= wdata[OW-1:0];
        end
        p_dma_map_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
            int'(dma_map[i]) < N_OWN);
    end

    for (genvar i = 0; i < N_INTF; i++) begin : g_intf
        // Interface owner register
        always_ff @(posedge clk) begin
            if (!rst_n)
                if_map[i] <= '0;
            else if (map_ok && addr[5:4] == KIND_INTF && int'(addr[3:0]) == i)
                if_map[i] <= wdata[OW-1:0];
        end
    end

    for (genvar i = 0; i < N_GRP; i++) begin : g_grp
        // Group owner register
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_map[i] <= '0;
            else if (map_ok && addr[5:4] == KIND_GRP && int'(addr[3:0]) == i)
                grp_map[i] <= wdata[OW-1:0];
        end
    end

    for (genvar o = 0; o < N_OWN; o++) begin : g_en
        // Per-owner class enable mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                cls_en[o] <= '0;
            else if (en_wr && int'(addr[2:0]) == o)
                cls_en[o] <= wdata[NCLS-1:0];
        end
    end

    p_bad_map_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        map_bad |=> ($stable(dma_map) && $stable(if_map) && $stable(grp_map)));
endmodule

// File: rtl/irq_agg_status.sv
// Sticky event status, one bit per class and resource. Assumes events are
// levels sampled at the clock edge; a set request beats a same-cycle clear.
module irq_agg_status
    import irq_agg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCLS-1:0][W-1:0]     evt,
    input  logic [NCLS-1:0][W-1:0]     clr,
    output logic [NCLS-1:0][W-1:0]     st
);
    // Latch events, drop cleared bits, events win
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= '0;
        else
            st <= (st & ~clr) | evt;
    end

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & ~clr) != '0) |=> (($past(st) & ~$past(clr) & ~st) == '0));

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_agg_owner.sv
// Per-owner view: decodes which status bits each owner holds through the
// maps, masks status into the owner's detail view, forms the class summary
// under the enables and drives one interrupt per owner. Purely combinational.
module irq_agg_owner
    import irq_agg_pkg::*;
#(
    parameter int N_DMA  = 8,
    parameter int N_INTF = 4,
    parameter int N_GRP  = 2,
    parameter int N_OWN  = 5,
    parameter int OW     = 3,
    parameter int W      = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_DMA-1:0][OW-1:0]            dma_map,
    input  logic [N_INTF-1:0][OW-1:0]           if_map,
    input  logic [N_GRP-1:0][OW-1:0]            grp_map,
    input  logic [N_OWN-1:0][NCLS-1:0]          cls_en,
    input  logic [NCLS-1:0][W-1:0]              st,
    output logic [N_OWN-1:0][NCLS-1:0][W-1:0]   own,
    output logic [N_OWN-1:0][NCLS-1:0][W-1:0]   view,
    output logic [N_OWN-1:0][NCLS-1:0]          summary,
    output logic [N_OWN-1:0]                    irq
);
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam kind_e K   = class_kind(c);
        localparam int    CNT = (K == KIND_DMA) ? N_DMA : ((K == KIND_INTF) ? N_INTF : N_GRP);
        for (genvar r = 0; r < W; r++) begin : g_res
            logic [N_OWN-1:0] col;
            for (genvar o = 0; o < N_OWN; o++) begin : g_o
                if (r < CNT) begin : g_real
                    if (K == KIND_DMA) begin : g_d
                        assign own[o][c][r] = (int'(dma_map[r]) == o);
                    end else if (K == KIND_INTF) begin : g_i
                        assign own[o][c][r] = (int'(if_map[r]) == o);
                    end else begin : g_g
                        assign own[o][c][r] = (int'(grp_map[r]) == o);
                    end
                end else begin : g_pad
                    assign own[o][c][r] = 1'b0;
                end
                assign col[o] = own[o][c][r];
            end
            if (r < CNT) begin : g_chk
                p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    $onehot(col));
            end else begin : g_chk_pad
                p_pad_unowned_r11: assert property (@(posedge clk) disable iff (!rst_n)
                    col == '0);
            end
        end
    end

    for (genvar o = 0; o < N_OWN; o++) begin : g_owner
        assign view[o] = st & own[o];
        for (genvar c = 0; c < NCLS; c++) begin : g_sum
            assign summary[o][c] = cls_en[o][c] & (|view[o][c]);
        end
        assign irq[o] = |summary[o];

        p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cls_en[o] == '0) |-> !irq[o]);
    end
endmodule

// File: rtl/irq_agg_top.sv
// Two-level multi-owner interrupt aggregator. Packs event inputs into a
// class-by-resource array, decodes register writes into map/enable updates
// and owner-scoped write-one-to-clear, and multiplexes read data.
// Assumes W (largest resource count) <= 16 and N_OWN <= 8.
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int N_DMA  = 8,
    parameter int N_INTF = 4,
    parameter int N_GRP  = 2,
    parameter int N_OWN  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DMA-1:0]  evt_dma_period,
    input  logic [N_DMA-1:0]  evt_dma_xrun,
    input  logic [N_DMA-1:0]  evt_dma_err,
    input  logic [N_INTF-1:0] evt_if_xrun,
    input  logic [N_GRP-1:0]  evt_grp_done,
    input  logic [N_INTF-1:0] evt_rate,
    input  logic [N_INTF-1:0] evt_vfr,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [N_OWN-1:0]  irq
);
    localparam int OW = (N_OWN > 1) ? $clog2(N_OWN) : 1;
    localparam int W  = max3(N_DMA, N_INTF, N_GRP);

    logic                               wr_en;
    logic [N_DMA-1:0][OW-1:0]           dma_map;
    logic [N_INTF-1:0][OW-1:0]          if_map;
    logic [N_GRP-1:0][OW-1:0]           grp_map;
    logic [N_OWN-1:0][NCLS-1:0]         cls_en;
    logic [NCLS-1:0][W-1:0]             evt, clr, status, sel_mask;
    logic [N_OWN-1:0][NCLS-1:0][W-1:0]  own, view;
    logic [N_OWN-1:0][NCLS-1:0]         summary;

    assign wr_en = reg_valid && reg_write;

    // Place each event input in its class row, zero-padded to W
    always_comb begin : p_pack
        evt = '0;
        evt[CLS_DMA_PERIOD][N_DMA-1:0] = evt_dma_period;
        evt[CLS_DMA_XRUN][N_DMA-1:0]   = evt_dma_xrun;
        evt[CLS_DMA_ERR][N_DMA-1:0]    = evt_dma_err;
        evt[CLS_IF_XRUN][N_INTF-1:0]   = evt_if_xrun;
        evt[CLS_GRP_DONE][N_GRP-1:0]   = evt_grp_done;
        evt[CLS_RATE][N_INTF-1:0]      = evt_rate;
        evt[CLS_VFR][N_INTF-1:0]       = evt_vfr;
    end

    // Clear only the addressed owner's bits of the addressed class
    always_comb begin : p_clear
        sel_mask = '0;
        for (int o = 0; o < N_OWN; o++)
            if (int'(reg_addr[5:3]) == o) sel_mask = own[o];
        clr = '0;
        if (wr_en && reg_addr[7:6] == RGN_STAT)
            for (int c = 0; c < NCLS; c++)
                if (int'(reg_addr[2:0]) == c) clr[c] = reg_wdata[W-1:0] & sel_mask[c];
    end

    irq_agg_cfg #(
        .N_DMA(N_DMA), .N_INTF(N_INTF), .N_GRP(N_GRP), .N_OWN(N_OWN), .OW(OW)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .dma_map(dma_map), .if_map(if_map), .grp_map(grp_map), .cls_en(cls_en)
    );

    irq_agg_status #(.W(W)) i_status (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .st(status)
    );

    irq_agg_owner #(
        .N_DMA(N_DMA), .N_INTF(N_INTF), .N_GRP(N_GRP), .N_OWN(N_OWN), .OW(OW), .W(W)
    ) i_owner (
        .clk(clk), .rst_n(rst_n), .dma_map(dma_map), .if_map(if_map), .grp_map(grp_map),
        .cls_en(cls_en), .st(status), .own(own), .view(view), .summary(summary), .irq(irq)
    );

    // Read multiplexer; anything unmatched reads as zero
    always_comb begin : p_read
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            case (reg_addr[7:6])
                RGN_MAP: begin
                    for (int i = 0; i < N_DMA; i++)
                        if (reg_addr[5:4] == KIND_DMA && int'(reg_addr[3:0]) == i)
                            reg_rdata[OW-1:0] = dma_map[i];
                    for (int i = 0; i < N_INTF; i++)
                        if (reg_addr[5:4] == KIND_INTF && int'(reg_addr[3:0]) == i)
                            reg_rdata[OW-1:0] = if_map[i];
                    for (int i = 0; i < N_GRP; i++)
                        if (reg_addr[5:4] == KIND_GRP && int'(reg_addr[3:0]) == i)
                            reg_rdata[OW-1:0] = grp_map[i];
                end
                RGN_EN: begin
                    for (int o = 0; o < N_OWN; o++)
                        if (int'(reg_addr[2:0]) == o) reg_rdata[NCLS-1:0] = cls_en[o];
                end
                RGN_SUM: begin
                    for (int o = 0; o < N_OWN; o++)
                        if (int'(reg_addr[2:0]) == o) reg_rdata[NCLS-1:0] = summary[o];
                end
                default: begin
                    for (int o = 0; o < N_OWN; o++)
                        for (int c = 0; c < NCLS; c++)
                            if (int'(reg_addr[5:3]) == o && int'(reg_addr[2:0]) == c)
                                reg_rdata[W-1:0] = view[o][c];
                end
            endcase
        end
    end
endmodule

// File: tb/test_irq_agg_top.sv
module test_irq_agg_top;
    localparam int ND = 8, NI = 4, NG = 2, NO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ND-1:0] evt_dma_period = '0, evt_dma_xrun = '0, evt_dma_err = '0;
    logic [NI-1:0] evt_if_xrun = '0, evt_rate = '0, evt_vfr = '0;
    logic [NG-1:0] evt_grp_done = '0;
    logic          reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    wire  [31:0]   reg_rdata;
    wire  [NO-1:0] irq;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // Reference model state
    int       m_map[3][16];
    bit       m_st[7][8];
    bit [6:0] m_en[NO];

    always #5 clk = ~clk;

    irq_agg_top #(.N_DMA(ND), .N_INTF(NI), .N_GRP(NG), .N_OWN(NO)) i_irq_agg_top (
        .clk(clk), .rst_n(rst_n),
        .evt_dma_period(evt_dma_period), .evt_dma_xrun(evt_dma_xrun), .evt_dma_err(evt_dma_err),
        .evt_if_xrun(evt_if_xrun), .evt_grp_done(evt_grp_done), .evt_rate(evt_rate), .evt_vfr(evt_vfr),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int kind_of(int c);
        if (c <= 2) return 0;
        if (c == 4) return 2;
        return 1;
    endfunction

    function automatic int count_of(int k);
        return (k == 0) ? ND : ((k == 1) ? NI : NG);
    endfunction

    function automatic int owner_of(int c, int r);
        int k;
        k = kind_of(c);
        if (r >= count_of(k)) return -1;
        return m_map[k][r];
    endfunction

    function automatic bit [7:0] m_view(int o, int c);
        bit [7:0] v;
        v = '0;
        for (int r = 0; r < 8; r++) if (m_st[c][r] && owner_of(c, r) == o) v[r] = 1'b1;
        return v;
    endfunction

    function automatic bit [6:0] m_sum(int o);
        bit [6:0] s;
        s = '0;
        for (int c = 0; c < 7; c++) s[c] = m_en[o][c] && (m_view(o, c) != 0);
        return s;
    endfunction

    function automatic bit evt_at(int c, int r);
        case (c)
            0: return (r < ND) ? evt_dma_period[r] : 1'b0;
            1: return (r < ND) ? evt_dma_xrun[r]   : 1'b0;
            2: return (r < ND) ? evt_dma_err[r]    : 1'b0;
            3: return (r < NI) ? evt_if_xrun[r]    : 1'b0;
            4: return (r < NG) ? evt_grp_done[r]   : 1'b0;
            5: return (r < NI) ? evt_rate[r]       : 1'b0;
            default: return (r < NI) ? evt_vfr[r]  : 1'b0;
        endcase
    endfunction

    function automatic bit [31:0] m_read(bit [7:0] a);
        int rg, k, i, o, c;
        rg = int'(a[7:6]);
        if (rg == 0) begin
            k = int'(a[5:4]); i = int'(a[3:0]);
            if (k < 3 && i < count_of(k)) return 32'(m_map[k][i]);
            return 0;
        end
        if (rg == 1) begin
            o = int'(a[2:0]);
            return (o < NO) ? 32'(m_en[o]) : 0;
        end
        if (rg == 2) begin
            o = int'(a[2:0]);
            return (o < NO) ? 32'(m_sum(o)) : 0;
        end
        o = int'(a[5:3]); c = int'(a[2:0]);
        return (o < NO && c < 7) ? 32'(m_view(o, c)) : 0;
    endfunction

    // Reference model, advanced on each rising edge from the driven inputs
    always @(posedge clk) begin : model
        int o, c, k, i;
        if (!rst_n) begin
            for (int a = 0; a < 3; a++) for (int b = 0; b < 16; b++) m_map[a][b] = 0;
            for (int a = 0; a < 7; a++) for (int b = 0; b < 8; b++) m_st[a][b] = 1'b0;
            for (int a = 0; a < NO; a++) m_en[a] = '0;
        end else begin
            if (reg_valid && reg_write && reg_addr[7:6] == 2'd3) begin
                o = int'(reg_addr[5:3]); c = int'(reg_addr[2:0]);
                if (o < NO && c < 7)
                    for (int r = 0; r < 8; r++)
                        if (reg_wdata[r] && owner_of(c, r) == o) m_st[c][r] = 1'b0;
            end
            for (int a = 0; a < 7; a++)
                for (int r = 0; r < 8; r++)
                    if (evt_at(a, r)) m_st[a][r] = 1'b1;
            if (reg_valid && reg_write && reg_addr[7:6] == 2'd0) begin
                k = int'(reg_addr[5:4]); i = int'(reg_addr[3:0]);
                if (k < 3 && i < count_of(k) && reg_wdata < NO) m_map[k][i] = int'(reg_wdata);
            end
            if (reg_valid && reg_write && reg_addr[7:6] == 2'd1) begin
                o = int'(reg_addr[2:0]);
                if (o < NO) m_en[o] = reg_wdata[6:0];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every cycle: each interrupt line against the model (R6)
    always @(negedge clk) begin
        if (rst_n && !finished)
            for (int o = 0; o < NO; o++)
                chk(irq[o] == (m_sum(o) != 0), "R6 per-cycle irq", irq[o], (m_sum(o) != 0));
    end

    function automatic bit [7:0] a_stat(int o, int c); return 8'hC0 | 8'(o << 3) | 8'(c); endfunction
    function automatic bit [7:0] a_map(int k, int i); return 8'(k << 4) | 8'(i); endfunction
    function automatic bit [7:0] a_en(int o);  return 8'h40 | 8'(o); endfunction
    function automatic bit [7:0] a_sum(int o); return 8'h80 | 8'(o); endfunction

    task automatic clear_evts();
        evt_dma_period = '0; evt_dma_xrun = '0; evt_dma_err = '0;
        evt_if_xrun = '0; evt_grp_done = '0; evt_rate = '0; evt_vfr = '0;
    endtask

    task automatic set_evt(input int c, input int r);
        case (c)
            0: evt_dma_period[r] = 1'b1;
            1: evt_dma_xrun[r]   = 1'b1;
            2: evt_dma_err[r]    = 1'b1;
            3: evt_if_xrun[r]    = 1'b1;
            4: evt_grp_done[r]   = 1'b1;
            5: evt_rate[r]       = 1'b1;
            default: evt_vfr[r]  = 1'b1;
        endcase
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        clear_evts();
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic pulse(input int c, input int r);
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        clear_evts(); set_evt(c, r);
        @(negedge clk);
        clear_evts();
    endtask

    task automatic clr_with_evt(input bit [7:0] a, input bit [31:0] d, input int c, input int r);
        @(negedge clk);
        clear_evts(); set_evt(c, r);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        clear_evts(); reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd_exp(input bit [7:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        clear_evts();
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        chk(reg_rdata == m_read(a), {tag, " model"}, reg_rdata, m_read(a));
    endtask

    task automatic irq_exp(input bit [NO-1:0] exp, input string tag);
        @(negedge clk);
        #1;
        chk(irq == exp, tag, irq, exp);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_exp(a_stat(0, 0), 32'h0, "R1 status after reset");
        rd_exp(a_map(0, 3), 32'h0, "R1 map after reset");
        rd_exp(a_en(0), 32'h0, "R1 enable after reset");
        irq_exp('0, "R1 irq after reset");

        // R2 latch, R7 disabled class quiet
        pulse(0, 2);
        rd_exp(a_stat(0, 0), 32'h4, "R2 DMA period ch2 latched");
        rd_exp(a_sum(0), 32'h0, "R7 summary with class disabled");
        irq_exp('0, "R7 irq with class disabled");

        // R5 / R6 enable the class
        wr(a_en(0), 32'h7F);
        rd_exp(a_sum(0), 32'h1, "R5 summary class 0");
        irq_exp(5'b00001, "R6 owner 0 irq");

        // R8 remap channel 2 to owner 3
        wr(a_map(0, 2), 32'd3);
        rd_exp(a_stat(0, 0), 32'h0, "R8 old owner loses status");
        rd_exp(a_stat(3, 0), 32'h4, "R8 new owner sees status");
        irq_exp('0, "R8 old owner irq drops");
        wr(a_en(3), 32'h1);
        irq_exp(5'b01000, "R6 owner 3 irq");

        // R3 owner-scoped write-one-to-clear
        wr(a_stat(0, 0), 32'hFF);
        rd_exp(a_stat(3, 0), 32'h4, "R3 foreign clear ignored");
        wr(a_stat(3, 0), 32'h0);
        rd_exp(a_stat(3, 0), 32'h4, "R3 zero write ignored");
        wr(a_stat(3, 0), 32'h4);
        rd_exp(a_stat(3, 0), 32'h0, "R3 owned clear");
        irq_exp('0, "R3 irq after clear");

        // R4 event beats simultaneous clear
        pulse(0, 5);
        clr_with_evt(a_stat(0, 0), 32'h20, 0, 5);
        rd_exp(a_stat(0, 0), 32'h20, "R4 event wins over clear");
        wr(a_stat(0, 0), 32'h20);
        rd_exp(a_stat(0, 0), 32'h0, "R4 later clear works");

        // R9 out-of-range owner ignored
        wr(a_map(0, 5), 32'd7);
        rd_exp(a_map(0, 5), 32'h0, "R9 owner 7 ignored");
        wr(a_map(0, 5), 32'd5);
        rd_exp(a_map(0, 5), 32'h0, "R9 owner 5 ignored");

        // R10 class to map association
        wr(a_map(1, 1), 32'd2);
        pulse(5, 1);
        pulse(6, 1);
        pulse(3, 1);
        rd_exp(a_stat(2, 5), 32'h2, "R10 rate via interface map");
        rd_exp(a_stat(2, 6), 32'h2, "R10 vfr via interface map");
        rd_exp(a_stat(2, 3), 32'h2, "R10 interface xrun via interface map");
        rd_exp(a_stat(0, 5), 32'h0, "R10 rate not under owner 0");
        wr(a_map(2, 1), 32'd4);
        pulse(4, 1);
        rd_exp(a_stat(4, 4), 32'h2, "R10 group done via group map");
        pulse(2, 1);
        rd_exp(a_stat(0, 2), 32'h2, "R10 DMA error via DMA map");

        // R11 out-of-range reads
        rd_exp(a_stat(6, 0), 32'h0, "R11 owner 6 status");
        rd_exp(8'h30, 32'h0, "R11 map kind 3");
        rd_exp(a_map(0, 12), 32'h0, "R11 DMA index 12");
        rd_exp(a_map(1, 5), 32'h0, "R11 interface index 5");

        // Random phase, checked against the model every cycle
        for (int n = 0; n < 600; n++) begin
            int op;
            @(negedge clk);
            evt_dma_period = ($urandom % 6 == 0) ? 8'($urandom) : '0;
            evt_dma_xrun   = ($urandom % 8 == 0) ? 8'($urandom) : '0;
            evt_dma_err    = ($urandom % 8 == 0) ? 8'($urandom) : '0;
            evt_if_xrun    = ($urandom % 8 == 0) ? 4'($urandom) : '0;
            evt_grp_done   = ($urandom % 8 == 0) ? 2'($urandom) : '0;
            evt_rate       = ($urandom % 8 == 0) ? 4'($urandom) : '0;
            evt_vfr        = ($urandom % 8 == 0) ? 4'($urandom) : '0;
            op = int'($urandom % 5);
            reg_valid = 1'b0; reg_write = 1'b0;
            case (op)
                1: begin
                    reg_valid = 1'b1; reg_write = 1'b1;
                    reg_addr = a_map(int'($urandom % 3), int'($urandom % 9));
                    reg_wdata = 32'($urandom_range(0, 6));
                end
                2: begin
                    reg_valid = 1'b1; reg_write = 1'b1;
                    reg_addr = a_en(int'($urandom % 6));
                    reg_wdata = 32'($urandom);
                end
                3: begin
                    reg_valid = 1'b1; reg_write = 1'b1;
                    reg_addr = a_stat(int'($urandom % 6), int'($urandom % 7));
                    reg_wdata = 32'($urandom);
                end
                4: begin
                    reg_valid = 1'b1; reg_write = 1'b0;
                    reg_addr = 8'($urandom);
                    #1;
                    chk(reg_rdata == m_read(reg_addr), "R5 random read", reg_rdata, m_read(reg_addr));
                end
                default: ;
            endcase
        end
        @(negedge clk);
        clear_evts(); reg_valid = 1'b0; reg_write = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule